// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface and programs the memory's two mode registers when asked to. The caller presents the wanted settings as field codes: burst length, burst ordering, read latency, DLL enable, output drive strength, QFC enable and a DLL reset request. The caller then pulses `start`. The sequencer checks the codes. When they are legal it issues a precharge of all banks and waits out the precharge time. It then writes the extended register, waits the register-set gap, writes the base register, waits the gap again and pulses `done`. When a code is reserved it pulses `error` and leaves the command bus at NOP.

The settings are captured on the clock edge that accepts `start`. Later changes on the setting inputs have no effect on a sequence already running. The block drives the chip-select/RAS/CAS/WE command pins, a 2-bit bank address and a 12-bit row address. While no command is due it drives NOP, with bank and address lines at zero.

States are `ST_IDLE`, `ST_PRECHARGE`, `ST_WAIT_RP`, `ST_EXT_WRITE`, `ST_WAIT_EXT`, `ST_BASE_WRITE`, `ST_WAIT_BASE`, `ST_DONE` and `ST_REJECT`. The transitions are:

- `ST_IDLE` goes to `ST_PRECHARGE` on `start` with legal codes, and to `ST_REJECT` on `start` with a reserved code.
- `ST_PRECHARGE` goes to `ST_WAIT_RP`.
- `ST_WAIT_RP` goes to `ST_EXT_WRITE` when its timer expires.
- `ST_EXT_WRITE` goes to `ST_WAIT_EXT`.
- `ST_WAIT_EXT` goes to `ST_BASE_WRITE` when its timer expires.
- `ST_BASE_WRITE` goes to `ST_WAIT_BASE`.
- `ST_WAIT_BASE` goes to `ST_DONE` when its timer expires.
- `ST_DONE` and `ST_REJECT` both return to `ST_IDLE`.

Top module: `mrs_program_seq`

## Requirements
- R1: During and after reset, with no start, the command pins show NOP. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1, with `ba`=0 and `addr`=0. `busy`, `done` and `error` are low.
- R2: One cycle after the edge that accepts `start` with legal codes, the block drives precharge-all for one cycle: cs_n=0, ras_n=0, cas_n=1, we_n=0, `addr`=12'h400 (bit 10 set), `ba`=0.
- R3: The extended register write comes exactly TRP_CYC cycles after the precharge. It drives all four command pins low with `ba`=2'b01. Its `addr` is {9'b0, qfc_enable, half_drive, dll_disable}: bit 0 is DLL (1 = disabled), bit 1 is drive (1 = half) and bit 2 is QFC (1 = on).
- R4: The base register write comes exactly MRD_CYC (2) cycles after the extended write. It drives all four command pins low with `ba`=2'b00. Its `addr` is {3'b0, dll_reset, 1'b0, cl_code, interleave, bl_code}: burst length on bits 2..0, ordering on bit 3, latency on bits 6..4 and DLL reset on bit 8.
- R5: Every cycle between the commands of a sequence is NOP. `done` is high for exactly one cycle, MRD_CYC cycles after the base write.
- R6: In the base write, bit 7 and bits 11..9 of `addr` are always 0.
- R7: A reserved burst length code (anything but 3'b001, 3'b010 or 3'b011) makes `start` produce a one-cycle `error` pulse one cycle later, and no command is issued. A reserved latency code (anything but 3'b010, 3'b011 or 3'b110) does the same.
- R8: A `start` pulse that arrives while a sequence runs is ignored. The running sequence keeps its timing and its captured settings, and no second sequence follows.
- R9: `busy` is high from the precharge cycle through the `done` cycle and low otherwise. It stays low in the error cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to program both registers |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | Burst ordering, 1 = interleaved |
| cl_code | input | 3 | Read latency code |
| dll_disable | input | 1 | 1 disables the DLL |
| half_drive | input | 1 | 1 selects half output drive |
| qfc_enable | input | 1 | 1 enables QFC |
| dll_reset | input | 1 | 1 requests a DLL reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle reserved-code pulse |

## Verification
Every result is counted from the clock edge that samples `start`. With the default TRP_CYC of 3, the precharge appears one cycle later, the extended write at cycle 4, the base write at cycle 6 and `done` at cycle 8. A rejected start shows `error` at cycle 1. Inputs change on the falling edge, and all outputs are sampled on the following falling edges for twelve consecutive cycles. The whole output vector is compared with the value due in that cycle index, so a command that comes early or late, or an extra one, fails the check for that cycle.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_EXT_WRITE,
        ST_WAIT_EXT,
        ST_BASE_WRITE,
        ST_WAIT_BASE,
        ST_DONE,
        ST_REJECT
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_MRW = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam int PRE_ALL_BIT = 10;

    function automatic logic burst_code_ok(input logic [2:0] code);
        case (code)
            3'b001, 3'b010, 3'b011: burst_code_ok = 1'b1;
            default:                burst_code_ok = 1'b0;
        endcase
    endfunction

    function automatic logic latency_code_ok(input logic [2:0] code);
        case (code)
            3'b010, 3'b011, 3'b110: latency_code_ok = 1'b1;
            default:                latency_code_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mrs_field_encoder.sv
module mrs_field_encoder
    import mrs_pkg::*;
(
    input  logic [2:0]        bl_code,
    input  logic              interleave,
    input  logic [2:0]        cl_code,
    input  logic              dll_disable,
    input  logic              half_drive,
    input  logic              qfc_enable,
    input  logic              dll_reset,
    output logic [ADDR_W-1:0] base_word,
    output logic [ADDR_W-1:0] ext_word,
    output logic              codes_legal
);

    always_comb begin
        base_word       = '0;
        base_word[2:0]  = bl_code;
        base_word[3]    = interleave;
        base_word[6:4]  = cl_code;
        base_word[7]    = 1'b0;
        base_word[8]    = dll_reset;

        ext_word        = '0;
        ext_word[0]     = dll_disable;
        ext_word[1]     = half_drive;
        ext_word[2]     = qfc_enable;

        codes_legal     = burst_code_ok(bl_code) && latency_code_ok(cl_code);
    end

    always_comb begin
        AST_TEST_BIT_LOW: assert (base_word[7] == 1'b0);                     // R6
        AST_RSVD_HIGH_LOW: assert (base_word[ADDR_W-1:9] == '0);             // R6
    end

endmodule

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             count_en,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (count_en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count_en && $past(rst_n) && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0); // R3

endmodule

// File: rtl/mrs_program_seq.sv
module mrs_program_seq
    import mrs_pkg::*;
#(
    parameter int TRP_CYC = 3,
    parameter int MRD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        bl_code,
    input  logic              interleave,
    input  logic [2:0]        cl_code,
    input  logic              dll_disable,
    input  logic              half_drive,
    input  logic              qfc_enable,
    input  logic              dll_reset,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              error
);

    localparam int WAIT_MAX = (TRP_CYC > MRD_CYC) ? TRP_CYC : MRD_CYC;
    localparam int CNT_W    = $clog2(WAIT_MAX) + 1;
    localparam int GAP_W    = CNT_W + 1;
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(TRP_CYC - 2);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(MRD_CYC - 2);

    initial begin
        AST_TRP_MIN: assert (TRP_CYC >= 2);  // R3
        AST_MRD_MIN: assert (MRD_CYC >= 2);  // R4
    end

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] base_word, ext_word;
    logic [ADDR_W-1:0] base_q, ext_q;
    logic              codes_legal;
    logic              tmr_load, tmr_count, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    dram_cmd_t         cmd;
    logic              accept;

    mrs_field_encoder u_enc (
        .bl_code     (bl_code),
        .interleave  (interleave),
        .cl_code     (cl_code),
        .dll_disable (dll_disable),
        .half_drive  (half_drive),
        .qfc_enable  (qfc_enable),
        .dll_reset   (dll_reset),
        .base_word   (base_word),
        .ext_word    (ext_word),
        .codes_legal (codes_legal)
    );

    mrs_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count_en (tmr_count),
        .expired  (tmr_expired)
    );

    assign accept = (state_q == ST_IDLE) && start && codes_legal;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = codes_legal ? ST_PRECHARGE : ST_REJECT;
            ST_PRECHARGE:  state_d = ST_WAIT_RP;
            ST_WAIT_RP:    if (tmr_expired) state_d = ST_EXT_WRITE;
            ST_EXT_WRITE:  state_d = ST_WAIT_EXT;
            ST_WAIT_EXT:   if (tmr_expired) state_d = ST_BASE_WRITE;
            ST_BASE_WRITE: state_d = ST_WAIT_BASE;
            ST_WAIT_BASE:  if (tmr_expired) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            ST_REJECT:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register and captured settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            ext_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q <= base_word;
                ext_q  <= ext_word;
            end
        end
    end

    // Timer control
    always_comb begin
        tmr_load  = (state_q == ST_PRECHARGE) || (state_q == ST_EXT_WRITE) ||
                    (state_q == ST_BASE_WRITE);
        tmr_val   = (state_q == ST_PRECHARGE) ? RP_LOAD : MRD_LOAD;
        tmr_count = (state_q == ST_WAIT_RP) || (state_q == ST_WAIT_EXT) ||
                    (state_q == ST_WAIT_BASE);
    end

    // Outputs
    always_comb begin
        cmd   = CMD_NOP;
        ba    = '0;
        addr  = '0;
        busy  = 1'b1;
        done  = 1'b0;
        error = 1'b0;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_PRECHARGE: begin
                cmd               = CMD_PRE;
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_EXT_WRITE: begin
                cmd  = CMD_MRW;
                ba   = BA_W'(1);
                addr = ext_q;
            end
            ST_BASE_WRITE: begin
                cmd  = CMD_MRW;
                ba   = '0;
                addr = base_q;
            end
            ST_DONE:       done = 1'b1;
            ST_REJECT: begin
                busy  = 1'b0;
                error = 1'b1;
            end
            default: ;
        endcase
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

    // Port-level history used by the assertions below
    dram_cmd_t        pin_cmd;
    dram_cmd_t        last_cmd_q;
    logic             last_ba0_q;
    logic [GAP_W-1:0] gap_q;
    logic             ext_seen_q;

    assign pin_cmd = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd_q <= CMD_NOP;
            last_ba0_q <= 1'b0;
            gap_q      <= '0;
            ext_seen_q <= 1'b0;
        end else begin
            if (pin_cmd != CMD_NOP) begin
                last_cmd_q <= pin_cmd;
                last_ba0_q <= ba[0];
                gap_q      <= GAP_W'(1);
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
            if (pin_cmd == CMD_MRW && ba[0])
                ext_seen_q <= 1'b1;
            else if (!busy)
                ext_seen_q <= 1'b0;
        end
    end

    AST_EXT_AFTER_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_MRW && ba[0]) |-> (last_cmd_q == CMD_PRE && int'(gap_q) >= TRP_CYC)); // R3
    AST_BASE_AFTER_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_MRW && !ba[0]) |-> (ext_seen_q && last_cmd_q == CMD_MRW && last_ba0_q)); // R4
    AST_REGISTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_NOP && last_cmd_q == CMD_MRW) |-> int'(gap_q) >= MRD_CYC); // R4
    AST_DONE_AFTER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_cmd_q == CMD_MRW && !last_ba0_q && int'(gap_q) >= MRD_CYC)); // R5
    AST_BASE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_MRW && !ba[0]) |-> (addr[7] == 1'b0 && addr[ADDR_W-1:9] == '0)); // R6
    AST_ERROR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (pin_cmd == CMD_NOP && !busy && !done)); // R7
    AST_ERROR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9

endmodule

// File: tb/tb_mrs_program_seq.sv
`timescale 1ns/1ps
module tb_mrs_program_seq;

    localparam int TRP = 3;
    localparam int MRD = 2;
    localparam int TRACE_LEN = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  bl_code = 3'b001;
    logic        interleave = 1'b0;
    logic [2:0]  cl_code = 3'b010;
    logic        dll_disable = 1'b0;
    logic        half_drive = 1'b0;
    logic        qfc_enable = 1'b0;
    logic        dll_reset = 1'b0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        busy, done, error;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mrs_program_seq #(.TRP_CYC(TRP), .MRD_CYC(MRD)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bl_code(bl_code), .interleave(interleave), .cl_code(cl_code),
        .dll_disable(dll_disable), .half_drive(half_drive),
        .qfc_enable(qfc_enable), .dll_reset(dll_reset),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .busy(busy), .done(done), .error(error)
    );

    // Output vector: {cs,ras,cas,we, ba, addr, busy, done, error}
    function automatic logic [20:0] pack(input logic [3:0] c, input logic [1:0] b,
                                         input logic [11:0] a, input logic bz,
                                         input logic dn, input logic er);
        return {c, b, a, bz, dn, er};
    endfunction

    function automatic logic [20:0] observed();
        return {cs_n, ras_n, cas_n, we_n, ba, addr, busy, done, error};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] bl, input logic it, input logic [2:0] cl,
                           input logic dd, input logic hd, input logic qf, input logic dr);
        bl_code = bl; interleave = it; cl_code = cl;
        dll_disable = dd; half_drive = hd; qfc_enable = qf; dll_reset = dr;
    endtask

    // Runs one request and compares every cycle of the trace.
    // inject: when set, a second start with other settings is raised at cycle 2.
    task automatic run_case(input string name, input logic [2:0] bl, input logic it,
                            input logic [2:0] cl, input logic dd, input logic hd,
                            input logic qf, input logic dr, input logic legal,
                            input logic inject);
        logic [11:0] exp_base = {3'b000, dr, 1'b0, cl, it, bl};
        logic [11:0] exp_ext  = {9'b0, qf, hd, dd};
        @(negedge clk);
        set_cfg(bl, it, cl, dd, hd, qf, dr);
        start = 1'b1;
        for (int t = 1; t <= TRACE_LEN; t++) begin
            logic [20:0] exp;
            string req;
            @(negedge clk);
            if (t == 1) start = 1'b0;
            if (inject && t == 2) begin
                set_cfg(3'b011, 1'b1, 3'b011, 1'b1, 1'b1, 1'b1, 1'b1);
                start = 1'b1;
            end
            if (inject && t == 3) start = 1'b0;
            if (!legal) begin
                exp = pack(4'b0111, 2'b00, 12'h000, 1'b0, 1'b0, t == 1);
                req = "R7";
            end else if (t == 1) begin
                exp = pack(4'b0010, 2'b00, 12'h400, 1'b1, 1'b0, 1'b0);
                req = "R2";
            end else if (t == 1 + TRP) begin
                exp = pack(4'b0000, 2'b01, exp_ext, 1'b1, 1'b0, 1'b0);
                req = "R3";
            end else if (t == 1 + TRP + MRD) begin
                exp = pack(4'b0000, 2'b00, exp_base, 1'b1, 1'b0, 1'b0);
                req = "R4";
            end else if (t == 1 + TRP + 2 * MRD) begin
                exp = pack(4'b0111, 2'b00, 12'h000, 1'b1, 1'b1, 1'b0);
                req = "R5";
            end else begin
                exp = pack(4'b0111, 2'b00, 12'h000, t < 1 + TRP + 2 * MRD, 1'b0, 1'b0);
                req = inject ? "R8" : "R9";
            end
            check(req, $sformatf("%s cycle %0d", name, t), observed(), exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "during reset", observed(), pack(4'b0111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "idle after reset", observed(), pack(4'b0111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic test_basic_programs();
        run_case("bl2 seq cl2",       3'b001, 1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_case("bl4 intl cl2.5 rst",3'b010, 1'b1, 3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_case("bl8 cl3 ext all",   3'b011, 1'b0, 3'b011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_reserved_codes();
        run_case("bl code 0 R7",  3'b000, 1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case("bl code 4 R7",  3'b100, 1'b0, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case("cl code 5 R7",  3'b010, 1'b0, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case("cl code 1 R7",  3'b011, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_start_while_busy();
        // R8: second start mid-sequence must change nothing
        run_case("busy restart", 3'b010, 1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        test_reset();
        test_basic_programs();
        test_reserved_codes();
        test_start_while_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule